// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It watches six request lines: one edge-triggered line that cannot be masked, one standard level-sensitive line, and four level-sensitive low-priority lines. When it accepts a request it raises a one-cycle take strobe together with a vector index, and it reports how many handlers are currently nested. The core signals the end of each handler with a one-cycle end-of-handler pulse.

Nesting has two tiers. The two high-priority sources may interrupt a handler that is running for any low-priority line. The low-priority lines never interrupt one another. A low-priority request that arrives while another low-priority handler runs stays pending, because it is a level, and it is granted as soon as that handler finishes. When no handler is active, a low-priority request is granted directly on the next clock edge.

The controller keeps a three-entry active stack: low tier, standard tier and non-maskable tier. Entries can only be pushed in rising order of tier, so an end-of-handler pulse always clears the highest set entry. That entry is the most recently entered level.

Top module: `ipc_ctrl`

## Requirements
- R1: After reset, take_o is 0, vec_o is 0 and level_o is 0.
- R2: A rising edge on nmi_i is latched and granted with vec_o = 0 one clock edge later if no non-maskable handler is active. A level held high does not trigger a second grant. An edge that arrives while that handler is active is kept and granted after the handler ends.
- R3: When a non-maskable grant and any other grant are possible in the same cycle, the non-maskable one (vec_o = 0) wins.
- R4: irq_i is granted only while irq_en_i = 1 and gmask_i = 0. Low-priority line i is granted only while lp_en_i[i] = 1 and gmask_i = 0. A masked or disabled request causes no take.
- R5: Among several eligible low-priority lines, the lowest-numbered line i is granted, with vec_o = 2 + i. irq_i is granted with vec_o = 1.
- R6: No low-priority request is granted while a low-priority handler is active. Such a request is granted after the end-of-handler pulse if it is still asserted.
- R7: irq_i or nmi_i may be granted while a low-priority handler is active. level_o then rises to 2.
- R8: irq_i is not granted while a standard or non-maskable handler is active. nmi_i may be granted while a standard handler is active.
- R9: level_o equals the number of active handlers. Each take raises it by one, and each eoh_i pulse clears the most recently entered level and lowers it by one.
- R10: take_o is high for exactly one cycle per grant, and vec_o keeps its last value between grants. No grant is made in a cycle in which eoh_i is high. The pending request is considered again in the following cycle.
- R11: No low-priority request is granted while a standard or non-maskable handler is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_i | input | 1 | Standard maskable request, level-sensitive |
| irq_en_i | input | 1 | Enable for irq_i |
| lp_req_i | input | NUM_LP | Low-priority request lines, level-sensitive |
| lp_en_i | input | NUM_LP | Per-line enables for lp_req_i |
| gmask_i | input | 1 | Global mask; 1 blocks irq_i and all low-priority lines |
| eoh_i | input | 1 | End-of-handler pulse from the core |
| take_o | output | 1 | One-cycle strobe when a request is accepted |
| vec_o | output | clog2(NUM_LP+2) | Vector index: 0 non-maskable, 1 standard, 2+i low-priority line i |
| level_o | output | 2 | Number of nested active handlers (0 to 3) |

## Verification
On every cycle the assertions check the following. The nesting count moves by exactly one on each take and on each end-of-handler pulse. No grant follows an end-of-handler cycle. A low-priority grant happens only with an empty stack. A standard grant happens only when it was enabled, unmasked and not blocked by an active high-tier handler. Behaviour that spans several cycles can only be shown by the bench scenarios. These cover a request that waits behind an active handler and is granted later, a non-maskable level held high that must not retrigger, lowest-line selection among several pending lines, and the order in which levels unwind.

// File: rtl/ipc_pkg.sv
// Shared constants for the two-tier interrupt priority controller.
// Assumes the active stack has exactly three tiers, in rising priority.
package ipc_pkg;
    localparam int unsigned TIER_LP     = 0;
    localparam int unsigned TIER_STD    = 1;
    localparam int unsigned TIER_NMI    = 2;
    localparam int unsigned TIER_COUNT  = 3;
    localparam int unsigned VEC_NMI     = 0;
    localparam int unsigned VEC_STD     = 1;
    localparam int unsigned VEC_LP_BASE = 2;
endpackage

// File: rtl/ipc_nmi_latch.sv
// Edge latch for the non-maskable request.
// Detects a rising edge on the raw input and holds it pending until the
// arbiter grants it. pend_o includes the edge seen in the current cycle,
// so a grant can follow one clock edge after the input rises.
// Assumes nmi_i is already synchronous to clk.
module ipc_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic grant_i,
    output logic pend_o
);
    logic nmi_q;
    logic pend_q;
    logic rise;

    // detect a low-to-high transition of the request
    assign rise   = nmi_i & ~nmi_q;
    assign pend_o = pend_q | rise;

    // remember the previous level and the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi_i;
            pend_q <= pend_o & ~grant_i;
        end
    end
endmodule

// File: rtl/ipc_lp_pick.sv
// Fixed-priority picker for the low-priority lines.
// The lowest-numbered asserted line wins. Purely combinational.
module ipc_lp_pick #(
    parameter int unsigned NUM_LP = 4,
    localparam int unsigned IDX_W = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
    input  logic [NUM_LP-1:0] req_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);
    // scan from the top down so that the lowest index is written last
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_LP - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipc_act_stack.sv
// Active-handler stack, one bit per tier.
// Push requests are assumed to be mutually exclusive and never to occur in
// the same cycle as a pop. Tiers are entered only in rising order, so a pop
// clears the highest set bit, which is the most recently entered level.
module ipc_act_stack import ipc_pkg::*; #(
    localparam int unsigned LVL_W = $clog2(TIER_COUNT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TIER_COUNT-1:0] push_i,
    input  logic                  pop_i,
    output logic [TIER_COUNT-1:0] act_o,
    output logic [LVL_W-1:0]      level_o
);
    logic [TIER_COUNT-1:0] act_q;
    logic [TIER_COUNT-1:0] pop_mask;

    // select the highest active tier for removal
    always_comb begin
        logic found;
        found    = 1'b0;
        pop_mask = '0;
        for (int t = TIER_COUNT - 1; t >= 0; t--) begin
            if (act_q[t] && !found) begin
                pop_mask[t] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // apply pushes and pops to the stack bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (pop_i) begin
            act_q <= act_q & ~pop_mask;
        end else begin
            act_q <= act_q | push_i;
        end
    end

    assign act_o   = act_q;
    assign level_o = LVL_W'($countones(act_q));
endmodule

// File: rtl/ipc_ctrl.sv
// Two-tier interrupt priority controller (top).
// Arbitrates one edge-triggered non-maskable line, one level-sensitive
// standard line and NUM_LP level-sensitive low-priority lines. A grant
// registers take_o, vec_o and the matching stack bit on the same edge.
// Assumes every input is synchronous to clk and that eoh_i is pulsed once
// per finished handler.
module ipc_ctrl import ipc_pkg::*; #(
    parameter int unsigned NUM_LP = 4,
    localparam int unsigned VEC_W = $clog2(NUM_LP + VEC_LP_BASE),
    localparam int unsigned LVL_W = $clog2(TIER_COUNT + 1),
    localparam int unsigned IDX_W = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic              irq_i,
    input  logic              irq_en_i,
    input  logic [NUM_LP-1:0] lp_req_i,
    input  logic [NUM_LP-1:0] lp_en_i,
    input  logic              gmask_i,
    input  logic              eoh_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [LVL_W-1:0]  level_o
);
    logic                  nmi_pend;
    logic                  grant_nmi;
    logic                  grant_std;
    logic                  grant_lp;
    logic                  lp_any;
    logic [IDX_W-1:0]      lp_idx;
    logic [NUM_LP-1:0]     lp_ok;
    logic [TIER_COUNT-1:0] act_q;
    logic [TIER_COUNT-1:0] push;
    logic [VEC_W-1:0]      vec_d;
    logic                  take_q;
    logic [VEC_W-1:0]      vec_q;

    ipc_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_i   (nmi_i),
        .grant_i (grant_nmi),
        .pend_o  (nmi_pend)
    );

    // qualify low-priority lines with their enables and the global mask
    assign lp_ok = lp_req_i & lp_en_i & {NUM_LP{~gmask_i}};

    ipc_lp_pick #(.NUM_LP(NUM_LP)) u_pick (
        .req_i (lp_ok),
        .any_o (lp_any),
        .idx_o (lp_idx)
    );

    // choose at most one grant per cycle, none while a handler is closing
    always_comb begin
        grant_nmi = !eoh_i && nmi_pend && !act_q[TIER_NMI];
        grant_std = !eoh_i && !grant_nmi && irq_i && irq_en_i && !gmask_i
                    && !act_q[TIER_STD] && !act_q[TIER_NMI];
        grant_lp  = !eoh_i && !grant_nmi && !grant_std && lp_any
                    && (act_q == '0);
    end

    // map the winning source to a stack bit and a vector index
    always_comb begin
        push           = '0;
        push[TIER_NMI] = grant_nmi;
        push[TIER_STD] = grant_std;
        push[TIER_LP]  = grant_lp;
        if (grant_nmi) begin
            vec_d = VEC_W'(VEC_NMI);
        end else if (grant_std) begin
            vec_d = VEC_W'(VEC_STD);
        end else begin
            vec_d = VEC_W'(VEC_LP_BASE) + VEC_W'(lp_idx);
        end
    end

    ipc_act_stack u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (eoh_i),
        .act_o   (act_q),
        .level_o (level_o)
    );

    // register the take strobe and hold the vector of the last grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= |push;
            if (|push) begin
                vec_q <= vec_d;
            end
        end
    end

    assign take_o = take_q;
    assign vec_o  = vec_q;
endmodule

// File: rtl/ipc_ctrl_chk.sv
// Property checker for ipc_ctrl, attached through bind. It observes the
// ports and the active-stack bits, which the stack module drives.
module ipc_ctrl_chk import ipc_pkg::*; #(
    parameter int unsigned NUM_LP = 4,
    localparam int unsigned VEC_W = $clog2(NUM_LP + VEC_LP_BASE),
    localparam int unsigned LVL_W = $clog2(TIER_COUNT + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_i,
    input logic                  irq_en_i,
    input logic                  gmask_i,
    input logic                  eoh_i,
    input logic                  take_o,
    input logic [VEC_W-1:0]      vec_o,
    input logic [LVL_W-1:0]      level_o,
    input logic [TIER_COUNT-1:0] act_i
);
    // R9
    take_raises_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (level_o == $past(level_o) + LVL_W'(1)));

    // R9
    eoh_lowers_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoh_i) && $past(level_o) != '0) |-> (level_o == $past(level_o) - LVL_W'(1)));

    // R10
    no_take_after_eoh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eoh_i) |-> !take_o);

    // R6
    lp_needs_empty_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o >= VEC_W'(VEC_LP_BASE)) |-> ($past(level_o) == '0));

    // R8
    std_not_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(VEC_STD)) |-> (!$past(act_i[TIER_STD]) && !$past(act_i[TIER_NMI])));

    // R4
    std_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(VEC_STD)) |-> $past(irq_i && irq_en_i && !gmask_i));

    // R2
    nmi_not_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(VEC_NMI)) |-> !$past(act_i[TIER_NMI]));
endmodule

bind ipc_ctrl ipc_ctrl_chk #(.NUM_LP(NUM_LP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_i),
    .irq_en_i (irq_en_i),
    .gmask_i  (gmask_i),
    .eoh_i    (eoh_i),
    .take_o   (take_o),
    .vec_o    (vec_o),
    .level_o  (level_o),
    .act_i    (act_q)
);

// File: tb/ipc_ctrl_tb.sv
module ipc_ctrl_tb;
    localparam int unsigned NUM_LP = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              nmi, irq, irq_en, gmask, eoh;
    logic [NUM_LP-1:0] lp_req, lp_en;
    logic              take;
    logic [2:0]        vec;
    logic [1:0]        level;

    int checks = 0;
    int errors = 0;

    // behavioural expectation state
    logic [2:0] m_act;
    logic       m_pend, m_prev;
    logic       exp_take;
    int         exp_vec, exp_level;

    ipc_ctrl #(.NUM_LP(NUM_LP)) u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_i(irq), .irq_en_i(irq_en),
        .lp_req_i(lp_req), .lp_en_i(lp_en), .gmask_i(gmask), .eoh_i(eoh),
        .take_o(take), .vec_o(vec), .level_o(level)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected result of one clock edge, from the requirements
    task automatic predict();
        logic rise, pend_n;
        int   g;
        rise   = nmi && !m_prev;
        pend_n = m_pend || rise;
        g      = -1;
        if (eoh) begin
            if (m_act[2]) m_act[2] = 1'b0;
            else if (m_act[1]) m_act[1] = 1'b0;
            else m_act[0] = 1'b0;
        end else if (pend_n && !m_act[2]) begin
            g = 0;
        end else if (irq && irq_en && !gmask && !m_act[1] && !m_act[2]) begin
            g = 1;
        end else if (m_act == 3'b000 && !gmask) begin
            for (int i = NUM_LP - 1; i >= 0; i--)
                if (lp_req[i] && lp_en[i]) g = 2 + i;
        end
        if (g == 0) begin m_act[2] = 1'b1; pend_n = 1'b0; end
        else if (g == 1) m_act[1] = 1'b1;
        else if (g >= 2) m_act[0] = 1'b1;
        m_pend   = pend_n;
        m_prev   = nmi;
        exp_take = (g >= 0);
        if (g >= 0) exp_vec = g;
        exp_level = $countones(m_act);
    endtask

    task automatic step(input string tag);
        predict();
        @(posedge clk);
        #1;
        chk(take == exp_take, {tag, " take"}, int'(take), int'(exp_take));
        chk(int'(vec) == exp_vec, {tag, " vec"}, int'(vec), exp_vec);
        chk(int'(level) == exp_level, {tag, " level"}, int'(level), exp_level);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        nmi = 0; irq = 0; irq_en = 0; gmask = 0; eoh = 0; lp_req = '0; lp_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        clear_inputs();
        rst_n = 0;
        m_act = '0; m_pend = 0; m_prev = 0; exp_vec = 0; exp_level = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(take == 1'b0, "R1 reset take", int'(take), 0);
        chk(vec == 3'd0, "R1 reset vec", int'(vec), 0);
        chk(level == 2'd0, "R1 reset level", int'(level), 0);

        // R2: edge grant, no retrigger on held level
        nmi = 1; step("R2 nmi edge taken");
        step("R2 held nmi no retake");
        eoh = 1; step("R9 eoh pops nmi");
        eoh = 0; step("R2 no retrigger after eoh");
        nmi = 0; step("R2 idle");

        // R3 / R8: priority and nesting of the high tier
        nmi = 1; irq = 1; irq_en = 1; step("R3 nmi beats irq");
        step("R8 irq blocked under nmi");
        eoh = 1; step("R10 no grant in eoh cycle");
        eoh = 0; step("R3 irq follows");
        step("R8 irq no self preempt");
        nmi = 0; step("R8 quiet");
        nmi = 1; step("R8 nmi preempts irq");
        eoh = 1; step("R9 pops nmi first");
        irq = 0; step("R9 pops irq");
        eoh = 0; nmi = 0; step("R9 empty");

        // R4: enables and global mask
        lp_req = 4'b0100; step("R4 disabled lp ignored");
        lp_en = 4'hF; gmask = 1; step("R4 mask blocks lp");
        irq = 1; step("R4 mask blocks irq");
        irq = 0; gmask = 0; step("R5 lp2 taken");

        // R6 / R5 / R7 / R11
        lp_req = 4'b0111; step("R6 no lp while lp active");
        eoh = 1; step("R10 eoh closes lp");
        eoh = 0; step("R5 lowest lp first");
        irq = 1; step("R7 irq preempts lp");
        lp_req = 4'b1111; step("R11 lp blocked under irq");
        eoh = 1; irq = 0; step("R9 pops irq over lp");
        step("R9 pops lp");
        eoh = 0; lp_req = 4'b1010; step("R5 lp1 over lp3");
        nmi = 1; step("R7 nmi preempts lp");
        eoh = 1; nmi = 0; lp_req = '0; step("R9 unwind");
        step("R9 unwind last");
        eoh = 0; clear_inputs(); step("R1 idle");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            nmi    = ($urandom % 8 == 0) ? ~nmi : nmi;
            irq    = ($urandom % 4 == 0);
            irq_en = ($urandom % 4 != 0);
            gmask  = ($urandom % 8 == 0);
            eoh    = ($urandom % 5 == 0);
            lp_req = 4'($urandom);
            lp_en  = 4'($urandom) | 4'b0011;
            step("R9 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule